// File: doc/BRIEF.md
# Burst-Splitting Chip-Select Memory Controller

This controller connects a bus master to a simple asynchronous memory, such as an SRAM, with a 64-bit data port. The master asks for either a single 8-byte transfer or a multi-beat burst. The memory cannot take data on consecutive clocks. The controller therefore runs each burst as a chain of complete single-beat memory cycles. It keeps chip select low across the whole chain, gives every beat its own strobe pulse, and returns one acknowledge per beat.

The block runs on a fast clock at four times the bus rate. A free-running phase counter divides each bus clock into four quarters, so strobe edges can be placed a quarter bus clock apart. The configuration inputs set three things: the wait-state count that fixes how many bus clocks each beat lasts, an option that releases write enable one quarter early on every beat, and an option that also allows 16-byte and 24-byte transfers.

The master holds `req_valid` with stable request fields until it sees the last acknowledge or an error pulse. During a write, the master places the data for the next beat on `req_wdata` as soon as it sees the acknowledge of the current beat.

Top module: `cs_burst_ctrl`

## Requirements
- R1: While `rst` is high and after it is released, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, and `xfer_ack` and `xfer_err` are 0, until a request arrives.
- R2: `req_size` selects the number of beats. Code 0 is one 8-byte beat and code 3 is a 32-byte burst of four beats. Codes 1 and 2 are 16 bytes (two beats) and 24 bytes (three beats), and they are legal only when `cfg_ext_en` is 1.
- R3: The first beat drives `mem_addr` = `req_addr`, and each later beat drives the previous address plus 8. `mem_addr` does not change within a beat.
- R4: `mem_cs_n` is 0 through every beat of a transfer, including the boundaries between beats. It rises exactly 4 fast clocks (one bus clock) after the fast clock that carries the last acknowledge.
- R5: In each beat, the active strobe (`mem_oe_n` for reads, `mem_we_n` for writes) is 1 in the first fast clock of the beat and 0 for the rest of the beat. The other strobe stays 1.
- R6: Each beat lasts 4·max(`cfg_wait`,1) fast clocks. `xfer_ack` is 1 for exactly one fast clock, which is the last fast clock of each beat.
- R7: With `cfg_early_we` = 1, `mem_we_n` is also 1 in the last fast clock of each write beat, on every beat of a burst. This is one quarter bus clock before the address and data change.
- R8: For reads, `rd_data` holds the memory data of the current beat during the fast clock in which `xfer_ack` is 1.
- R9: For writes, `mem_wdata` takes `req_wdata` when a beat starts and holds it through that beat. For the first beat this is the value present at acceptance. For each later beat it is the value present at the end of the previous beat's acknowledge clock.
- R10: A request is rejected in these cases: an illegal size (R2), a single beat whose `req_addr[2:0]` is not 0, a 16-byte transfer whose `req_addr[3:0]` is not 0, or a 24-byte or 32-byte transfer whose `req_addr[4:0]` is not 0. A rejected request gives a one-fast-clock `xfer_err` pulse, and `mem_cs_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four times the bus rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wait | input | 4 | Bus clocks per beat (0 is treated as 1) |
| cfg_early_we | input | 1 | Release write enable one quarter early on every beat |
| cfg_ext_en | input | 1 | Allow 16-byte and 24-byte transfers |
| req_valid | input | 1 | Request present; held until the last ack or an error |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Beat count minus one |
| req_addr | input | 16 | Byte start address |
| req_wdata | input | 64 | Write data for the beat being started |
| mem_rdata | input | 64 | Data returned by the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 64 | Memory write data |
| xfer_ack | output | 1 | One pulse per completed beat |
| xfer_err | output | 1 | Pulse on a rejected request |
| rd_data | output | 64 | Read data, valid with `xfer_ack` |

## Verification
An error in the beat or wait counter shows up at once at the ports. The gap between acknowledges is no longer four times the wait count, or chip select rises too early or too late around the recovery clock. A wrong address register shows up at the first acknowledge of the next beat as an address step other than 8. It also shows up as wrong data read back from the bench memory. A wrong strobe decode shows up within one beat as a low count other than 4·N−1, or 4·N−2 with early release. The same fault can also appear as write enable low during an acknowledge, or as both strobes low together.

// File: rtl/cs_mc_pkg.sv
package cs_mc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BEAT  = 2'd1,
    ST_RECOV = 2'd2
  } ctl_state_e;

  localparam int unsigned PHASES = 4;
endpackage

// File: rtl/cs_phase_gen.sv
module cs_phase_gen #(
  parameter int unsigned PHASES = 4,
  localparam int unsigned PW = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] phase
);
  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase + PW'(1);
  end

  a_r6_phase_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> phase == PW'($past(phase) + PW'(1)));
endmodule

// File: rtl/cs_req_check.sv
module cs_req_check (
  input  logic [1:0] size,
  input  logic [4:0] addr_lo,
  input  logic       ext_en,
  output logic       ok
);
  always_comb begin
    case (size)
      2'd0:    ok = (addr_lo[2:0] == 3'd0);
      2'd1:    ok = ext_en && (addr_lo[3:0] == 4'd0);
      2'd2:    ok = ext_en && (addr_lo == 5'd0);
      default: ok = (addr_lo == 5'd0);
    endcase
  end

  always_comb begin
    a_r10_ok_aligned: assert (!ok || addr_lo[2:0] == 3'd0);
  end
endmodule

// File: rtl/cs_burst_ctrl.sv
module cs_burst_ctrl
  import cs_mc_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 64,
  parameter int unsigned WW = 4,
  localparam int unsigned PW = $clog2(PHASES),
  localparam int unsigned BEAT_BYTES = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [WW-1:0] cfg_wait,
  input  logic          cfg_early_we,
  input  logic          cfg_ext_en,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_cs_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          xfer_ack,
  output logic          xfer_err,
  output logic [DW-1:0] rd_data
);
  ctl_state_e    st;
  logic [PW-1:0] phase;
  logic          req_ok;
  logic [1:0]    beats_left;
  logic [WW-1:0] clk_left;
  logic [WW-1:0] wait_q;
  logic [WW-1:0] wait_eff;
  logic          wr_q, early_q;
  logic          phase_end, beat_end, last_nx;

  cs_phase_gen #(.PHASES(PHASES)) i_phase (
    .clk(clk), .rst(rst), .phase(phase)
  );

  cs_req_check i_check (
    .size(req_size), .addr_lo(req_addr[4:0]), .ext_en(cfg_ext_en), .ok(req_ok)
  );

  assign wait_eff  = (cfg_wait == '0) ? WW'(1) : cfg_wait;
  assign phase_end = (phase == PW'(PHASES - 1));
  assign beat_end  = phase_end && (clk_left == '0);
  assign last_nx   = (phase == PW'(PHASES - 2)) && (clk_left == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      mem_cs_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      xfer_ack   <= 1'b0;
      xfer_err   <= 1'b0;
      rd_data    <= '0;
      beats_left <= '0;
      clk_left   <= '0;
      wait_q     <= WW'(1);
      wr_q       <= 1'b0;
      early_q    <= 1'b0;
    end else begin
      xfer_ack <= 1'b0;
      xfer_err <= 1'b0;
      case (st)
        ST_IDLE: begin
          mem_cs_n <= 1'b1;
          mem_oe_n <= 1'b1;
          mem_we_n <= 1'b1;
          if (phase_end && req_valid) begin
            if (req_ok) begin
              st         <= ST_BEAT;
              mem_cs_n   <= 1'b0;
              mem_addr   <= req_addr;
              mem_wdata  <= req_wdata;
              beats_left <= req_size;
              wr_q       <= req_write;
              early_q    <= cfg_early_we;
              wait_q     <= wait_eff;
              clk_left   <= wait_eff - WW'(1);
            end else begin
              xfer_err <= 1'b1;
            end
          end
        end
        ST_BEAT: begin
          if (beat_end) begin
            mem_oe_n <= 1'b1;
            mem_we_n <= 1'b1;
            if (beats_left == 2'd0) begin
              st <= ST_RECOV;
            end else begin
              beats_left <= beats_left - 2'd1;
              mem_addr   <= mem_addr + AW'(BEAT_BYTES);
              mem_wdata  <= req_wdata;
              clk_left   <= wait_q - WW'(1);
            end
          end else begin
            mem_oe_n <= wr_q;
            mem_we_n <= !wr_q || (early_q && last_nx);
            xfer_ack <= last_nx;
            if (last_nx && !wr_q) rd_data <= mem_rdata;
            if (phase_end) clk_left <= clk_left - WW'(1);
          end
        end
        default: begin
          if (phase_end) begin
            st       <= ST_IDLE;
            mem_cs_n <= 1'b1;
          end
        end
      endcase
    end
  end

  a_r6_ack_single: assert property (@(posedge clk) disable iff (rst)
    xfer_ack |=> !xfer_ack);
  a_r4_cs_on_ack: assert property (@(posedge clk) disable iff (rst)
    xfer_ack |-> !mem_cs_n);
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BEAT && !xfer_ack) |=> $stable(mem_addr));
  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    mem_oe_n || mem_we_n);
  a_r10_err_no_cs: assert property (@(posedge clk) disable iff (rst)
    xfer_err |-> mem_cs_n);
  a_r7_early_we: assert property (@(posedge clk) disable iff (rst)
    (early_q && xfer_ack) |-> mem_we_n);
endmodule

// File: tb/test_cs_burst_ctrl.sv
module test_cs_burst_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cfg_wait = 4'd1;
  logic        cfg_early_we = 1'b0;
  logic        cfg_ext_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [15:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [63:0] mem_rdata;
  logic        mem_cs_n, mem_oe_n, mem_we_n, xfer_ack, xfer_err;
  logic [15:0] mem_addr;
  logic [63:0] mem_wdata, rd_data;
  logic [63:0] mem [0:63];
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  assign mem_rdata = mem[mem_addr[8:3]];

  cs_burst_ctrl i_cs_burst_ctrl (
    .clk(clk), .rst(rst), .cfg_wait(cfg_wait), .cfg_early_we(cfg_early_we),
    .cfg_ext_en(cfg_ext_en), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_rdata(mem_rdata), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .xfer_ack(xfer_ack), .xfer_err(xfer_err), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    chk(mem_cs_n && mem_oe_n && mem_we_n && !xfer_ack && !xfer_err,
        "R1 outputs in reset", {mem_cs_n, mem_oe_n, mem_we_n, xfer_ack, xfer_err}, 5'b11100);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    chk(mem_cs_n && mem_oe_n && mem_we_n && !xfer_ack && !xfer_err,
        "R1 outputs after reset", {mem_cs_n, mem_oe_n, mem_we_n, xfer_ack, xfer_err}, 5'b11100);
  endtask

  task automatic run_xfer(input bit wr, input logic [1:0] sz, input logic [15:0] a,
                          input logic [3:0] w, input bit early, input bit ext,
                          input logic [63:0] seed);
    int nb = int'(sz) + 1;
    int n = (w == 4'd0) ? 1 : int'(w);
    int beat = 0;
    int since = 0;
    int low = 0;
    int guard = 0;
    bit started = 0;
    bit other_bad = 0;
    bit cs_bad = 0;
    int exp_low = (wr && early) ? 4 * n - 2 : 4 * n - 1;
    cfg_wait = w; cfg_early_we = early; cfg_ext_en = ext;
    req_write = wr; req_size = sz; req_addr = a; req_wdata = seed; req_valid = 1'b1;
    while (beat < nb && guard < 2000) begin
      @(negedge clk);
      guard++;
      if (!mem_cs_n) started = 1;
      if (started) begin
        since++;
        if (mem_cs_n) cs_bad = 1;
        if (!(wr ? mem_we_n : mem_oe_n)) low++;
        if (!(wr ? mem_oe_n : mem_we_n)) other_bad = 1;
        if (wr && !mem_we_n) mem[mem_addr[8:3]] = mem_wdata;
      end
      if (xfer_ack) begin
        chk(mem_addr == 16'(a + 16'(8 * beat)), "R3 beat address", mem_addr, 16'(a + 16'(8 * beat)));
        chk(since == 4 * n, "R6 beat length", since, 4 * n);
        chk(low == exp_low, wr && early ? "R7 early strobe count" : "R5 strobe count", low, exp_low);
        if (wr) begin
          chk(mem_wdata == seed + 64'(beat), "R9 write data", mem_wdata, seed + 64'(beat));
          if (early) chk(mem_we_n, "R7 we high at ack", mem_we_n, 1);
        end else begin
          chk(rd_data == mem[mem_addr[8:3]], "R8 read data", rd_data, mem[mem_addr[8:3]]);
        end
        since = 0; low = 0; beat++;
        if (beat < nb) req_wdata = seed + 64'(beat);
        else req_valid = 1'b0;
      end
    end
    chk(guard < 2000, "R2 transfer completes", guard, 0);
    chk(beat == nb, "R2 beat count", beat, nb);
    chk(!cs_bad, "R4 cs held across beats", cs_bad, 0);
    chk(!other_bad, "R5 idle strobe stays high", other_bad, 0);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      chk(!mem_cs_n && !xfer_ack, "R4 cs held in recovery", {mem_cs_n, xfer_ack}, 0);
    end
    @(negedge clk);
    chk(mem_cs_n, "R4 cs negated after recovery", mem_cs_n, 1);
  endtask

  task automatic t_reject(input string why, input logic [1:0] sz, input logic [15:0] a,
                          input bit ext);
    bit seen = 0;
    bit cs_low = 0;
    cfg_ext_en = ext; req_write = 1'b0; req_size = sz; req_addr = a; req_valid = 1'b1;
    for (int k = 0; k < 10 && !seen; k++) begin
      @(negedge clk);
      if (!mem_cs_n) cs_low = 1;
      if (xfer_err) seen = 1;
    end
    req_valid = 1'b0;
    chk(seen, {"R10 error pulse ", why}, seen, 1);
    chk(!cs_low, {"R10 no cycle ", why}, cs_low, 0);
    @(negedge clk);
    chk(!xfer_err && mem_cs_n, {"R10 error one clock ", why}, {xfer_err, mem_cs_n}, 2'b01);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_memcheck(input logic [15:0] a, input int nb, input logic [63:0] seed);
    for (int b = 0; b < nb; b++)
      chk(mem[6'(a[8:3] + 6'(b))] == seed + 64'(b), "R9 stored word",
          mem[6'(a[8:3] + 6'(b))], seed + 64'(b));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 64'hA5A5_0000_0000_0000 | 64'(i);
    t_reset();
    run_xfer(1'b0, 2'd0, 16'h0040, 4'd1, 1'b0, 1'b0, 64'h0);
    run_xfer(1'b1, 2'd3, 16'h0080, 4'd2, 1'b0, 1'b0, 64'h1000);
    t_memcheck(16'h0080, 4, 64'h1000);
    run_xfer(1'b0, 2'd3, 16'h0080, 4'd0, 1'b0, 1'b0, 64'h0);
    run_xfer(1'b1, 2'd3, 16'h00A0, 4'd3, 1'b1, 1'b0, 64'h2000);
    t_memcheck(16'h00A0, 4, 64'h2000);
    run_xfer(1'b0, 2'd1, 16'h0090, 4'd1, 1'b0, 1'b1, 64'h0);
    run_xfer(1'b1, 2'd2, 16'h00C0, 4'd1, 1'b1, 1'b1, 64'h3000);
    t_memcheck(16'h00C0, 3, 64'h3000);
    t_reject("16B without ext", 2'd1, 16'h0100, 1'b0);
    t_reject("32B misaligned", 2'd3, 16'h0088, 1'b0);
    t_reject("8B misaligned", 2'd0, 16'h0044, 1'b0);
    t_reject("24B misaligned", 2'd2, 16'h00C8, 1'b1);
    run_xfer(1'b1, 2'd0, 16'h0108, 4'd1, 1'b0, 1'b0, 64'h4000);
    t_memcheck(16'h0108, 1, 64'h4000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule